// File: doc/BRIEF.md
# Shifter Operand Generation Unit

This unit forms the second operand of a 32-bit data-processing ALU, together with the shifter carry-out that the ALU may later write to its carry flag. It is purely combinational. A two-bit mode select chooses one of three operand sources. The first source shifts a register value by a 5-bit amount taken from the instruction. The second shifts the same register value by the low byte of a second register. The third rotates an 8-bit constant right by an even amount.

The four shift kinds are logical left, logical right, arithmetic right and rotate right. Their boundary amounts follow fixed rules. Zero passes the value through. Exactly the word width and anything beyond it each saturate in their own way. An encoded immediate amount of zero is given new meanings for the right shifts and for rotation. The ALU itself and flag writeback sit downstream of this unit.

Top module: `shifter_operand_unit`

## Requirements
- R1: In immediate-shift mode (mode 2'b00), an encoded amount of 0 with LSR (kind 2'b01) yields 0 with carry equal to bit 31 of the value. With ASR (kind 2'b10) it yields all copies of bit 31, with carry equal to bit 31.
- R2: In immediate-shift mode, LSL (kind 2'b00) by an encoded amount of 0 outputs the value unchanged, and the carry-out equals the incoming carry flag.
- R3: For an amount n from 1 to 31 in either shift mode, LSL, LSR and ASR produce the shifted value, with ASR filling from bit 31. The carry-out is the last bit shifted out: bit 32−n for LSL and bit n−1 for the right shifts.
- R4: In immediate-shift mode, ROR (kind 2'b11) by an amount of 1 to 31 rotates the value right, with carry equal to bit 31 of the result. An amount of 0 instead gives {carry flag, value[31:1]} with carry equal to value bit 0.
- R5: In register-shift mode (mode 2'b01), only bits 7:0 of the shift register form the amount. An amount of 0 leaves the value unchanged, with carry equal to the carry flag, for every kind.
- R6: In register-shift mode, LSL by exactly 32 gives 0 with carry equal to bit 0, and LSR by exactly 32 gives 0 with carry equal to bit 31. Both give 0 with carry 0 for amounts of 33 and more.
- R7: In register-shift mode, ASR by 32 or more gives 32 copies of bit 31, with carry equal to bit 31.
- R8: In register-shift mode, ROR uses the amount modulo 32, and for any nonzero amount the carry equals bit 31 of the result. A nonzero multiple of 32 therefore leaves the value unchanged, with carry equal to its bit 31.
- R9: In rotated-immediate mode (mode bit 1 set, so 2'b10 and 2'b11 behave alike), the zero-extended 8-bit constant is rotated right by twice the 4-bit rotate field. The carry equals the carry flag when the field is 0, and equals bit 31 of the result otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| i_mode | input | 2 | Operand source: 00 immediate shift, 01 register shift, 1x rotated immediate |
| i_kind | input | 2 | Shift kind: 00 LSL, 01 LSR, 10 ASR, 11 ROR |
| i_rm_val | input | 32 | Register value to be shifted |
| i_imm_amt | input | 5 | Shift amount from the instruction |
| i_rs_val | input | 32 | Register holding the shift amount (low byte used) |
| i_rot_field | input | 4 | Half of the right-rotate amount for the constant |
| i_imm8 | input | 8 | 8-bit constant |
| i_carry_in | input | 1 | Current carry flag |
| o_operand | output | 32 | Second ALU operand |
| o_carry | output | 1 | Shifter carry-out |

## Verification
Both results are combinational functions of the current inputs, so each is due in the same cycle as its stimulus, with no register in the path. The bench changes the inputs just after a falling clock edge. It samples operand and carry one time unit later, well before the next rising edge, so each check sees one settled input set. Expected values come from a one-bit-per-step shift model in the bench and from hand-worked constants for the saturating amounts.

// File: rtl/shop_pkg.sv
`timescale 1ns/1ps
package shop_pkg;

    typedef enum logic [1:0] {
        SK_LSL = 2'd0,
        SK_LSR = 2'd1,
        SK_ASR = 2'd2,
        SK_ROR = 2'd3
    } shift_kind_e;

    typedef enum logic [1:0] {
        SRC_IMM_SHIFT = 2'd0,
        SRC_REG_SHIFT = 2'd1,
        SRC_ROT_CONST = 2'd2,
        SRC_ROT_ALIAS = 2'd3
    } operand_src_e;

endpackage

// File: rtl/shop_amount_sel.sv
`timescale 1ns/1ps
// Picks the effective shift amount and flags the rotate-through-carry case.
module shop_amount_sel
    import shop_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int IMM_AMT_W = 5,
    parameter int AMT_W     = 8
) (
    input  logic                 use_reg,
    input  shift_kind_e          kind,
    input  logic [IMM_AMT_W-1:0] imm_amt,
    input  logic [AMT_W-1:0]     reg_amt,
    output logic [AMT_W-1:0]     amt,
    output logic                 rrx
);
    localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DATA_W);

    logic imm_zero;
    assign imm_zero = (imm_amt == '0);

    always_comb begin
        amt = '0;
        rrx = 1'b0;
        if (use_reg) begin
            amt = reg_amt;
        end else begin
            amt = AMT_W'(imm_amt);
            if (imm_zero) begin
                unique case (kind)
                    SK_LSR, SK_ASR: amt = FULL_AMT;
                    SK_ROR:         rrx = 1'b1;
                    default:        amt = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/shop_barrel.sv
`timescale 1ns/1ps
// Shifts a register value by an amount that may exceed the word width.
module shop_barrel
    import shop_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8
) (
    input  logic [DATA_W-1:0] val,
    input  shift_kind_e       kind,
    input  logic [AMT_W-1:0]  amt,
    input  logic              rrx,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output logic              cout
);
    localparam int LOG_W = $clog2(DATA_W);
    localparam int IDX_W = LOG_W + 1;
    localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DATA_W);

    logic              in_range;
    logic [IDX_W-1:0]  a_sm;
    logic [IDX_W-1:0]  a_sat;
    logic [LOG_W-1:0]  idx_left;
    logic [LOG_W-1:0]  idx_right;
    logic [LOG_W-1:0]  idx_sat;
    logic [LOG_W-1:0]  rot_amt;
    logic [IDX_W-1:0]  rot_back;
    logic [DATA_W-1:0] rot_val;

    assign in_range  = (amt <= FULL_AMT);
    assign a_sm      = in_range ? amt[IDX_W-1:0] : '0;
    assign a_sat     = in_range ? a_sm : IDX_W'(DATA_W);
    assign idx_left  = LOG_W'(DATA_W - int'(a_sm));
    assign idx_right = LOG_W'(int'(a_sm) - 1);
    assign idx_sat   = LOG_W'(int'(a_sat) - 1);
    assign rot_amt   = amt[LOG_W-1:0];
    assign rot_back  = IDX_W'(DATA_W - int'(rot_amt));
    assign rot_val   = (val >> rot_amt) | (val << rot_back);

    always_comb begin
        res  = val;
        cout = cin;
        if (rrx) begin
            res  = {cin, val[DATA_W-1:1]};
            cout = val[0];
        end else if (amt != '0) begin
            unique case (kind)
                SK_LSL: begin
                    res  = in_range ? (val << a_sm) : '0;
                    cout = in_range ? val[idx_left] : 1'b0;
                end
                SK_LSR: begin
                    res  = in_range ? (val >> a_sm) : '0;
                    cout = in_range ? val[idx_right] : 1'b0;
                end
                SK_ASR: begin
                    res  = DATA_W'($signed(val) >>> a_sat);
                    cout = val[idx_sat];
                end
                SK_ROR: begin
                    res  = rot_val;
                    cout = rot_val[DATA_W-1];
                end
                default: begin
                    res  = val;
                    cout = cin;
                end
            endcase
        end
    end
endmodule

// File: rtl/shop_rotimm.sv
`timescale 1ns/1ps
// Rotates a zero-extended constant right by an even amount.
module shop_rotimm #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8,
    parameter int ROT_W  = 4
) (
    input  logic [IMM_W-1:0]  imm,
    input  logic [ROT_W-1:0]  rot,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output logic              cout
);
    localparam int LOG_W = $clog2(DATA_W);
    localparam int IDX_W = LOG_W + 1;

    logic [DATA_W-1:0] ext;
    logic [LOG_W-1:0]  r_amt;
    logic [IDX_W-1:0]  r_back;

    assign ext    = DATA_W'(imm);
    assign r_amt  = LOG_W'({rot, 1'b0});
    assign r_back = IDX_W'(DATA_W - int'(r_amt));
    assign res    = (ext >> r_amt) | (ext << r_back);
    assign cout   = (rot == '0) ? cin : res[DATA_W-1];
endmodule

// File: rtl/shifter_operand_unit.sv
`timescale 1ns/1ps
module shifter_operand_unit
    import shop_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int IMM_AMT_W = 5,
    parameter int REG_AMT_W = 8,
    parameter int IMM_W     = 8,
    parameter int ROT_W     = 4
) (
    input  logic [1:0]           i_mode,
    input  logic [1:0]           i_kind,
    input  logic [DATA_W-1:0]    i_rm_val,
    input  logic [IMM_AMT_W-1:0] i_imm_amt,
    input  logic [DATA_W-1:0]    i_rs_val,
    input  logic [ROT_W-1:0]     i_rot_field,
    input  logic [IMM_W-1:0]     i_imm8,
    input  logic                 i_carry_in,
    output logic [DATA_W-1:0]    o_operand,
    output logic                 o_carry
);
    operand_src_e      src;
    shift_kind_e       kind;
    logic [REG_AMT_W-1:0] eff_amt;
    logic              rrx;
    logic [DATA_W-1:0] sh_res;
    logic              sh_c;
    logic [DATA_W-1:0] ri_res;
    logic              ri_c;
    logic              unused_rs_hi;

    assign src          = operand_src_e'(i_mode);
    assign kind         = shift_kind_e'(i_kind);
    assign unused_rs_hi = ^i_rs_val[DATA_W-1:REG_AMT_W];

    shop_amount_sel #(
        .DATA_W(DATA_W), .IMM_AMT_W(IMM_AMT_W), .AMT_W(REG_AMT_W)
    ) u_amt (
        .use_reg (i_mode[0]),
        .kind    (kind),
        .imm_amt (i_imm_amt),
        .reg_amt (i_rs_val[REG_AMT_W-1:0]),
        .amt     (eff_amt),
        .rrx     (rrx)
    );

    shop_barrel #(.DATA_W(DATA_W), .AMT_W(REG_AMT_W)) u_shift (
        .val  (i_rm_val),
        .kind (kind),
        .amt  (eff_amt),
        .rrx  (rrx),
        .cin  (i_carry_in),
        .res  (sh_res),
        .cout (sh_c)
    );

    shop_rotimm #(.DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_rot (
        .imm  (i_imm8),
        .rot  (i_rot_field),
        .cin  (i_carry_in),
        .res  (ri_res),
        .cout (ri_c)
    );

    always_comb begin
        unique case (src)
            SRC_IMM_SHIFT, SRC_REG_SHIFT: begin
                o_operand = sh_res;
                o_carry   = sh_c;
            end
            default: begin
                o_operand = ri_res;
                o_carry   = ri_c;
            end
        endcase
    end
endmodule

// File: rtl/shop_checker.sv
`timescale 1ns/1ps
module shop_checker #(
    parameter int DATA_W    = 32,
    parameter int IMM_AMT_W = 5,
    parameter int REG_AMT_W = 8,
    parameter int IMM_W     = 8,
    parameter int ROT_W     = 4
) (
    input logic [1:0]           i_mode,
    input logic [1:0]           i_kind,
    input logic [DATA_W-1:0]    i_rm_val,
    input logic [IMM_AMT_W-1:0] i_imm_amt,
    input logic [DATA_W-1:0]    i_rs_val,
    input logic [ROT_W-1:0]     i_rot_field,
    input logic [IMM_W-1:0]     i_imm8,
    input logic                 i_carry_in,
    input logic [DATA_W-1:0]    o_operand,
    input logic                 o_carry
);
    localparam int WAMT = DATA_W;
    logic [REG_AMT_W-1:0] ra;
    logic                 sgn;
    assign ra  = i_rs_val[REG_AMT_W-1:0];
    assign sgn = i_rm_val[DATA_W-1];

    always_comb begin
        if (i_mode == 2'b00 && i_kind == 2'b01 && i_imm_amt == '0)
            AST_IMM_LSR_ZERO: assert (o_operand == '0 && o_carry == sgn); // R1
        if (i_mode == 2'b00 && i_kind == 2'b00 && i_imm_amt == '0)
            AST_IMM_LSL_PASS: assert (o_operand == i_rm_val && o_carry == i_carry_in); // R2
        if (i_mode == 2'b01 && ra == '0)
            AST_REG_ZERO_PASS: assert (o_operand == i_rm_val && o_carry == i_carry_in); // R5
        if (i_mode == 2'b01 && i_kind[1] == 1'b0 && int'(ra) > WAMT)
            AST_REG_BEYOND_ZERO: assert (o_operand == '0 && o_carry == 1'b0); // R6
        if (i_mode == 2'b01 && i_kind == 2'b10 && int'(ra) >= WAMT)
            AST_REG_ASR_FILL: assert (o_operand == {DATA_W{sgn}} && o_carry == sgn); // R7
        if (i_mode == 2'b01 && i_kind == 2'b11 && ra != '0)
            AST_REG_ROR_CARRY: assert (o_carry == o_operand[DATA_W-1]); // R8
        if (i_mode[1] && i_rot_field == '0)
            AST_ROT_ZERO_CONST: assert (o_operand == DATA_W'(i_imm8) && o_carry == i_carry_in); // R9
        if (i_mode[1] && i_rot_field != '0)
            AST_ROT_CARRY_MSB: assert (o_carry == o_operand[DATA_W-1]); // R9
    end
endmodule

bind shifter_operand_unit shop_checker #(
    .DATA_W(DATA_W), .IMM_AMT_W(IMM_AMT_W), .REG_AMT_W(REG_AMT_W),
    .IMM_W(IMM_W), .ROT_W(ROT_W)
) u_chk (.*);

// File: tb/shifter_operand_unit_test.sv
`timescale 1ns/1ps
module shifter_operand_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 200000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [1:0]  mode;
    logic [1:0]  kind;
    logic [31:0] rm;
    logic [4:0]  imm_amt;
    logic [31:0] rs;
    logic [3:0]  rot;
    logic [7:0]  imm8;
    logic        cin;
    logic [31:0] operand;
    logic        carry;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    shifter_operand_unit uut (
        .i_mode(mode), .i_kind(kind), .i_rm_val(rm), .i_imm_amt(imm_amt),
        .i_rs_val(rs), .i_rot_field(rot), .i_imm8(imm8), .i_carry_in(cin),
        .o_operand(operand), .o_carry(carry)
    );

    // One bit per step; carry tracks the last bit moved out.
    function automatic void model(input logic [1:0] m, input logic [1:0] k,
                                  input logic [31:0] v, input logic [4:0] ia,
                                  input logic [31:0] rsv, input logic [3:0] rf,
                                  input logic [7:0] c8, input logic ci,
                                  output logic [31:0] r, output logic c);
        int n;
        r = v; c = ci;
        if (m[1]) begin
            r = {24'd0, c8};
            for (int i = 0; i < 2 * int'(rf); i++) r = {r[0], r[31:1]};
            c = (rf == 0) ? ci : r[31];
            return;
        end
        n = m[0] ? int'(rsv[7:0]) : int'(ia);
        if (!m[0] && n == 0) begin
            if (k == 2'b01 || k == 2'b10) n = 32;
            if (k == 2'b11) begin
                r = {ci, v[31:1]}; c = v[0];
                return;
            end
        end
        for (int i = 0; i < n; i++) begin
            case (k)
                2'b00: begin c = r[31]; r = r << 1; end
                2'b01: begin c = r[0];  r = r >> 1; end
                2'b10: begin c = r[0];  r = {r[31], r[31:1]}; end
                default: begin r = {r[0], r[31:1]}; c = r[31]; end
            endcase
        end
    endfunction

    task automatic apply(input logic [1:0] m, input logic [1:0] k, input logic [31:0] v,
                         input logic [4:0] ia, input logic [31:0] rsv, input logic [3:0] rf,
                         input logic [7:0] c8, input logic ci);
        @(negedge clk);
        mode = m; kind = k; rm = v; imm_amt = ia; rs = rsv; rot = rf; imm8 = c8; cin = ci;
        #1;
    endtask

    task automatic check(input string tag, input logic [31:0] er, input logic ec);
        checks++;
        if (operand !== er || carry !== ec) begin
            errors++;
            $display("FAIL %s: operand=%h carry=%b expected operand=%h carry=%b",
                     tag, operand, carry, er, ec);
        end
    endtask

    task automatic check_model(input string tag);
        logic [31:0] er; logic ec;
        model(mode, kind, rm, imm_amt, rs, rot, imm8, cin, er, ec);
        check(tag, er, ec);
    endtask

    task automatic t_reset_state();
        @(negedge clk); #1;
        check("R2 idle inputs", 32'd0, 1'b0);
    endtask

    task automatic t_imm_lsl_zero();
        apply(2'b00, 2'b00, 32'hDEAD_BEEF, 5'd0, 32'd7, 4'd0, 8'd0, 1'b1);
        check("R2 lsl imm0 carry1", 32'hDEAD_BEEF, 1'b1);
        apply(2'b00, 2'b00, 32'h8000_0001, 5'd0, 32'd7, 4'd0, 8'd0, 1'b0);
        check("R2 lsl imm0 carry0", 32'h8000_0001, 1'b0);
    endtask

    task automatic t_imm_right_zero();
        apply(2'b00, 2'b01, 32'h8000_0000, 5'd0, 32'd0, 4'd0, 8'd0, 1'b0);
        check("R1 lsr imm0", 32'd0, 1'b1);
        apply(2'b00, 2'b10, 32'h9000_0000, 5'd0, 32'd0, 4'd0, 8'd0, 1'b0);
        check("R1 asr imm0 neg", 32'hFFFF_FFFF, 1'b1);
        apply(2'b00, 2'b10, 32'h7FFF_FFFF, 5'd0, 32'd0, 4'd0, 8'd0, 1'b1);
        check("R1 asr imm0 pos", 32'd0, 1'b0);
    endtask

    task automatic t_imm_mid();
        apply(2'b00, 2'b00, 32'h0000_0003, 5'd31, 32'd0, 4'd0, 8'd0, 1'b0);
        check("R3 lsl 31", 32'h8000_0000, 1'b1);
        apply(2'b00, 2'b01, 32'h0000_0010, 5'd5, 32'd0, 4'd0, 8'd0, 1'b0);
        check("R3 lsr 5", 32'd0, 1'b1);
        apply(2'b00, 2'b10, 32'h8000_0000, 5'd1, 32'd0, 4'd0, 8'd0, 1'b1);
        check("R3 asr 1", 32'hC000_0000, 1'b0);
        for (int k = 0; k < 3; k++)
            for (int a = 1; a < 32; a += 5) begin
                apply(2'b00, 2'(k), 32'hA5C3_0F96, 5'(a), 32'd0, 4'd0, 8'd0, 1'b0);
                check_model("R3 imm sweep");
            end
    endtask

    task automatic t_imm_ror_rrx();
        apply(2'b00, 2'b11, 32'h0000_0001, 5'd0, 32'd0, 4'd0, 8'd0, 1'b1);
        check("R4 rrx", 32'h8000_0000, 1'b1);
        apply(2'b00, 2'b11, 32'h0000_0002, 5'd0, 32'd0, 4'd0, 8'd0, 1'b0);
        check("R4 rrx cin0", 32'h0000_0001, 1'b0);
        apply(2'b00, 2'b11, 32'h0000_0001, 5'd1, 32'd0, 4'd0, 8'd0, 1'b0);
        check("R4 ror 1", 32'h8000_0000, 1'b1);
        apply(2'b00, 2'b11, 32'h1234_5678, 5'd8, 32'd0, 4'd0, 8'd0, 1'b1);
        check("R4 ror 8", 32'h7812_3456, 1'b0);
    endtask

    task automatic t_reg_zero();
        for (int k = 0; k < 4; k++) begin
            apply(2'b01, 2'(k), 32'hCAFE_F00D, 5'd9, 32'hFFFF_FF00, 4'd0, 8'd0, 1'b1);
            check("R5 reg amount 0 high bits ignored", 32'hCAFE_F00D, 1'b1);
        end
        apply(2'b01, 2'b00, 32'h0000_0001, 5'd0, 32'h0000_0104, 4'd0, 8'd0, 1'b0);
        check("R5 low byte only", 32'h0000_0010, 1'b0);
    endtask

    task automatic t_reg_lsl_lsr_edges();
        apply(2'b01, 2'b00, 32'h8000_0001, 5'd0, 32'd32, 4'd0, 8'd0, 1'b0);
        check("R6 lsl 32", 32'd0, 1'b1);
        apply(2'b01, 2'b00, 32'hFFFF_FFFF, 5'd0, 32'd33, 4'd0, 8'd0, 1'b1);
        check("R6 lsl 33", 32'd0, 1'b0);
        apply(2'b01, 2'b01, 32'h8000_0001, 5'd0, 32'd32, 4'd0, 8'd0, 1'b0);
        check("R6 lsr 32", 32'd0, 1'b1);
        apply(2'b01, 2'b01, 32'hFFFF_FFFF, 5'd0, 32'd255, 4'd0, 8'd0, 1'b1);
        check("R6 lsr 255", 32'd0, 1'b0);
    endtask

    task automatic t_reg_asr_edges();
        apply(2'b01, 2'b10, 32'h8000_0000, 5'd0, 32'd32, 4'd0, 8'd0, 1'b0);
        check("R7 asr 32 neg", 32'hFFFF_FFFF, 1'b1);
        apply(2'b01, 2'b10, 32'h7FFF_FFFF, 5'd0, 32'd200, 4'd0, 8'd0, 1'b1);
        check("R7 asr 200 pos", 32'd0, 1'b0);
    endtask

    task automatic t_reg_ror_wrap();
        apply(2'b01, 2'b11, 32'h8000_0001, 5'd0, 32'd32, 4'd0, 8'd0, 1'b0);
        check("R8 ror 32", 32'h8000_0001, 1'b1);
        apply(2'b01, 2'b11, 32'h0000_0001, 5'd0, 32'd33, 4'd0, 8'd0, 1'b0);
        check("R8 ror 33", 32'h8000_0000, 1'b1);
        apply(2'b01, 2'b11, 32'h0000_00F0, 5'd0, 32'd68, 4'd0, 8'd0, 1'b1);
        check("R8 ror 68", 32'h0000_000F, 1'b0);
    endtask

    task automatic t_boundaries();
        int amts[6] = '{0, 1, 31, 32, 33, 255};
        for (int k = 0; k < 4; k++)
            foreach (amts[i]) begin
                apply(2'b01, 2'(k), 32'hF0F0_1234, 5'd0, 32'(amts[i]), 4'd0, 8'd0, 1'b1);
                check_model("R6 R7 R8 boundary");
                apply(2'b01, 2'(k), 32'h0F0F_EDCB, 5'd0, 32'(amts[i]), 4'd0, 8'd0, 1'b0);
                check_model("R6 R7 R8 boundary");
            end
    endtask

    task automatic t_rot_const();
        apply(2'b10, 2'b00, 32'd0, 5'd0, 32'd0, 4'd0, 8'hAB, 1'b1);
        check("R9 rot 0", 32'h0000_00AB, 1'b1);
        apply(2'b10, 2'b00, 32'd0, 5'd0, 32'd0, 4'd1, 8'h03, 1'b0);
        check("R9 rot 2", 32'hC000_0000, 1'b1);
        apply(2'b11, 2'b00, 32'd0, 5'd0, 32'd0, 4'd4, 8'hFF, 1'b1);
        check("R9 alias rot 8", 32'hFF00_0000, 1'b1);
        apply(2'b10, 2'b00, 32'd0, 5'd0, 32'd0, 4'd15, 8'h81, 1'b1);
        check("R9 rot 30", 32'h0000_0204, 1'b0);
    endtask

    task automatic t_random();
        for (int i = 0; i < 3000; i++) begin
            apply(2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), $urandom(),
                  5'($urandom_range(0, 31)), 32'($urandom_range(0, 300)),
                  4'($urandom_range(0, 15)), 8'($urandom_range(0, 255)), 1'($urandom_range(0, 1)));
            check_model("R3 R4 R9 random");
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * MAX_CYCLES);
        checks++;
        errors++;
        $display("FAIL watchdog: operand=%h carry=%b expected operand=%h carry=%b",
                 operand, carry, 32'd0, 1'b0);
        finish_run();
    end

    initial begin
        mode = 2'b00; kind = 2'b00; rm = '0; imm_amt = '0; rs = '0;
        rot = '0; imm8 = '0; cin = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_imm_lsl_zero();
        t_imm_right_zero();
        t_imm_mid();
        t_imm_ror_rrx();
        t_reg_zero();
        t_reg_lsl_lsr_edges();
        t_reg_asr_edges();
        t_reg_ror_wrap();
        t_boundaries();
        t_rot_const();
        t_random();
        finish_run();
    end
endmodule